// File: doc/BRIEF.md
# Saturating Rounding Narrowing Shifter

This block takes a vector of unsigned wide elements and produces a vector of half-width results. The wide element width is set by a 3-bit size code. Each element gets a round-to-nearest bias and is shifted right by an amount packed into the size code and a 3-bit immediate. The result is clamped to the unsigned range of the narrow element. It is then placed in the even-numbered narrow slot that sits at the bottom of its wide source position, and every odd-numbered narrow slot is written with zero. There is no predication: every slot is written on every accepted operation.

The operation is one registered stage. The result appears one clock after the input is presented with its valid strobe. Between operations the result registers hold their contents. The block also provides:
- a per-element flag for every element that was clamped;
- a sticky bit that records any clamp since reset;
- an illegal flag for the reserved size code, whose result is all zeros.

Top module: `sat_round_narrow`

## Requirements
- R1: The size code selects the narrow width N. Code 001 gives N=8, codes 010 and 011 give N=16, and codes 100 to 111 give N=32. Each wide source element is 2N bits.
- R2: The shift amount is 2N minus the unsigned 6-bit value {sizeCode, shImm}. This gives 1 to 8 for N=8, 1 to 16 for N=16 and 1 to 32 for N=32.
- R3: Before the shift, 2^(shift-1) is added to each wide element. The sum keeps its carry, so an all-ones element never wraps to a small value.
- R4: A shifted value larger than 2^N-1 is replaced by 2^N-1.
- R5: Wide element e (bits [2Ne +: 2N]) is processed into narrow slot 2e, which is bits [2Ne +: N]. Narrow slot 2e+1 is zero. VEC_W/(2N) elements are processed.
- R6: Size code 000 gives a result of all zeros and no saturation flags, with `illegal` high for that result.
- R7: `satFlags[e]` is high exactly when element e was clamped. Flag bits at or above VEC_W/(2N) are zero.
- R8: `satAny` goes high with the first result that has any saturation flag set. It then stays high until reset.
- R9: A result appears one cycle after `inValid`, with `outValid` high in that cycle only. When `inValid` is low, `dstVec`, `satFlags` and `illegal` keep their previous values.
- R10: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Accept an operation this cycle |
| sizeCode | input | 3 | Narrow element size code |
| shImm | input | 3 | Low bits of the packed shift immediate |
| srcVec | input | VEC_W | Source vector of wide unsigned elements |
| outValid | output | 1 | Result registered from the previous cycle |
| dstVec | output | VEC_W | Narrowed, interleaved result |
| illegal | output | 1 | Result came from the reserved size code |
| satFlags | output | VEC_W/16 | Per-element clamp flags |
| satAny | output | 1 | Sticky clamp indicator |

## Verification
The bench builds the block with VEC_W=128. This gives eight, four and two wide elements for the three sizes, so the per-element flag positions above the element count, and the odd-slot zeroing, are both visible in every mode. At N=32 the wide element is 64 bits, so an all-ones input with shift 32 needs the 65th carry bit. That case checks whether the rounding sum keeps its carry.

// File: rtl/srn_pkg.sv
package srn_pkg;
  localparam int NUM_WIDTHS  = 3;
  localparam int BASE_NARROW = 8;

  typedef struct packed {
    logic       load;
    logic       illegal;
    logic [2:0] widthSel;
    logic [5:0] shiftAmt;
  } srn_ctl_t;
endpackage

// File: rtl/srn_ctrl.sv
module srn_ctrl
  import srn_pkg::*;
(
  input  logic       inValid,
  input  logic [2:0] sizeCode,
  input  logic [2:0] shImm,
  output srn_ctl_t   ctl
);
  logic [6:0] packedImm;
  logic [6:0] twiceN;
  logic [6:0] diff;

  assign packedImm = {1'b0, sizeCode, shImm};

  always_comb begin
    ctl.widthSel = 3'b000;
    twiceN       = 7'd0;
    if (sizeCode[2]) begin
      ctl.widthSel = 3'b100;
      twiceN       = 7'd64;
    end else if (sizeCode[1]) begin
      ctl.widthSel = 3'b010;
      twiceN       = 7'd32;
    end else if (sizeCode[0]) begin
      ctl.widthSel = 3'b001;
      twiceN       = 7'd16;
    end
  end

  assign diff         = twiceN - packedImm;
  assign ctl.shiftAmt = (sizeCode == 3'b000) ? 6'd0 : diff[5:0];
  assign ctl.illegal  = (sizeCode == 3'b000);
  assign ctl.load     = inValid;
endmodule

// File: rtl/srn_datapath.sv
module srn_datapath
  import srn_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  srn_ctl_t             ctl,
  input  logic [VEC_W-1:0]     srcVec,
  output logic                 outValid,
  output logic [VEC_W-1:0]     dstVec,
  output logic                 illegal,
  output logic [VEC_W/16-1:0]  satFlags,
  output logic                 satAny
);
  localparam int MAX_EL = VEC_W / (2 * BASE_NARROW);

  logic [VEC_W-1:0]  laneVec  [NUM_WIDTHS];
  logic [MAX_EL-1:0] laneFlag [NUM_WIDTHS];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : gWidth
    localparam int NW  = BASE_NARROW << g;
    localparam int WW  = 2 * NW;
    localparam int CNT = VEC_W / WW;

    logic [VEC_W-1:0]  vecG;
    logic [MAX_EL-1:0] flagG;
    logic [WW:0]       roundK;

    assign roundK = {{WW{1'b0}}, 1'b1} << (ctl.shiftAmt - 6'd1);

    always_comb begin
      logic [WW:0] wideE;
      logic [WW:0] sumE;
      logic [WW:0] shE;
      vecG  = '0;
      flagG = '0;
      for (int e = 0; e < CNT; e++) begin
        wideE = {1'b0, srcVec[e*WW +: WW]};
        sumE  = wideE + roundK;
        shE   = sumE >> ctl.shiftAmt;
        if (|shE[WW:NW]) begin
          vecG[e*WW +: NW] = {NW{1'b1}};
          flagG[e]         = 1'b1;
        end else begin
          vecG[e*WW +: NW] = shE[NW-1:0];
        end
      end
    end

    assign laneVec[g]  = vecG;
    assign laneFlag[g] = flagG;
  end

  logic [VEC_W-1:0]  pickVec;
  logic [MAX_EL-1:0] pickFlag;

  always_comb begin
    pickVec  = '0;
    pickFlag = '0;
    for (int g = 0; g < NUM_WIDTHS; g++) begin
      if (ctl.widthSel[g]) begin
        pickVec  = pickVec | laneVec[g];
        pickFlag = pickFlag | laneFlag[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      dstVec   <= '0;
      illegal  <= 1'b0;
      satFlags <= '0;
      satAny   <= 1'b0;
    end else begin
      outValid <= ctl.load;
      if (ctl.load) begin
        illegal  <= ctl.illegal;
        dstVec   <= ctl.illegal ? '0 : pickVec;
        satFlags <= ctl.illegal ? '0 : pickFlag;
        if (!ctl.illegal && |pickFlag) satAny <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_round_narrow.sv
module sat_round_narrow
  import srn_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [2:0]          sizeCode,
  input  logic [2:0]          shImm,
  input  logic [VEC_W-1:0]    srcVec,
  output logic                outValid,
  output logic [VEC_W-1:0]    dstVec,
  output logic                illegal,
  output logic [VEC_W/16-1:0] satFlags,
  output logic                satAny
);
  srn_ctl_t ctl;

  srn_ctrl uCtrl (
    .inValid (inValid),
    .sizeCode(sizeCode),
    .shImm   (shImm),
    .ctl     (ctl)
  );

  srn_datapath #(.VEC_W(VEC_W)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .srcVec  (srcVec),
    .outValid(outValid),
    .dstVec  (dstVec),
    .illegal (illegal),
    .satFlags(satFlags),
    .satAny  (satAny)
  );
endmodule

// File: rtl/srn_checker.sv
module srn_checker #(
  parameter int VEC_W = 128
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [2:0]          sizeCode,
  input logic                outValid,
  input logic [VEC_W-1:0]    dstVec,
  input logic                illegal,
  input logic [VEC_W/16-1:0] satFlags,
  input logic                satAny
);
  logic [2:0] sizeQ;
  logic       layoutOk;

  always_ff @(posedge clk) begin
    if (!rstN)        sizeQ <= 3'b000;
    else if (inValid) sizeQ <= sizeCode;
  end

  always_comb begin
    int nw;
    nw = sizeQ[2] ? 32 : sizeQ[1] ? 16 : sizeQ[0] ? 8 : 0;
    layoutOk = 1'b1;
    if (nw != 0) begin
      for (int b = 0; b < VEC_W; b++)
        if (((b / nw) % 2 == 1) && dstVec[b]) layoutOk = 1'b0;
      for (int e = 0; e < VEC_W/16; e++)
        if ((e >= VEC_W / (2 * nw)) && satFlags[e]) layoutOk = 1'b0;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);                                   // R9
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);                                 // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(dstVec) && $stable(satFlags));      // R9
  AST_ILLEGAL_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeCode == 3'b000) |=> illegal);            // R6
  AST_ILLEGAL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (dstVec == '0) && (satFlags == '0));         // R6
  AST_ODD_SLOTS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> layoutOk);                                  // R5
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    satAny |=> satAny);                                      // R8
  AST_FLAG_SETS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && |satFlags) |-> satAny);                     // R8
endmodule

bind sat_round_narrow srn_checker #(.VEC_W(VEC_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .sizeCode(sizeCode),
  .outValid(outValid), .dstVec(dstVec), .illegal(illegal),
  .satFlags(satFlags), .satAny(satAny)
);

// File: tb/tb_sat_round_narrow.sv
module tb_sat_round_narrow;
  localparam int VEC_W  = 128;
  localparam int MAX_EL = VEC_W / 16;

  logic               clk = 1'b0;
  logic               rstN;
  logic               inValid;
  logic [2:0]         sizeCode;
  logic [2:0]         shImm;
  logic [VEC_W-1:0]   srcVec;
  logic               outValid;
  logic [VEC_W-1:0]   dstVec;
  logic               illegal;
  logic [MAX_EL-1:0]  satFlags;
  logic               satAny;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic              expValid = 0;
  logic [VEC_W-1:0]  expDst = '0;
  logic              expIllegal = 0;
  logic [MAX_EL-1:0] expFlags = '0;
  logic              expSticky = 0;
  string             pendTag = "R5";

  always #2 clk = ~clk;

  sat_round_narrow #(.VEC_W(VEC_W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sizeCode(sizeCode),
    .shImm(shImm), .srcVec(srcVec), .outValid(outValid), .dstVec(dstVec),
    .illegal(illegal), .satFlags(satFlags), .satAny(satAny)
  );

  task automatic check(input string req, input logic [VEC_W-1:0] act,
                       input logic [VEC_W-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [VEC_W-1:0] s, input logic [2:0] sz,
                       input logic [2:0] im, output logic [VEC_W-1:0] d,
                       output logic [MAX_EL-1:0] f, output logic ill);
    int n, sh, cnt;
    logic [64:0] wide, sum, r, lim;
    d = '0; f = '0; ill = 0;
    n = sz[2] ? 32 : sz[1] ? 16 : sz[0] ? 8 : 0;
    if (n == 0) begin ill = 1; return; end
    sh  = 2 * n - int'({sz, im});
    cnt = VEC_W / (2 * n);
    lim = (65'd1 << n) - 65'd1;
    for (int e = 0; e < cnt; e++) begin
      wide = '0;
      for (int b = 0; b < 2 * n; b++) wide[b] = s[e * 2 * n + b];
      sum = wide + (65'd1 << (sh - 1));
      r = sum >> sh;
      if (r > lim) begin r = lim; f[e] = 1'b1; end
      for (int b = 0; b < n; b++) d[e * 2 * n + b] = r[b];
    end
  endtask

  task automatic step(input logic v, input logic [2:0] sz, input logic [2:0] im,
                      input logic [VEC_W-1:0] s, input string tag);
    logic [VEC_W-1:0]  d;
    logic [MAX_EL-1:0] f;
    logic              ill;
    @(negedge clk);
    check("R9", VEC_W'(outValid), VEC_W'(expValid), "outValid");
    check(pendTag, dstVec, expDst, "dstVec");
    check("R6", VEC_W'(illegal), VEC_W'(expIllegal), "illegal");
    check("R7", VEC_W'(satFlags), VEC_W'(expFlags), "satFlags");
    check("R8", VEC_W'(satAny), VEC_W'(expSticky), "satAny");
    inValid = v; sizeCode = sz; shImm = im; srcVec = s;
    expValid = v;
    if (v) begin
      model(s, sz, im, d, f, ill);
      expDst = d; expFlags = f; expIllegal = ill;
      if (|f) expSticky = 1'b1;
      pendTag = tag;
    end else begin
      pendTag = "R9";
    end
  endtask

  function automatic logic [VEC_W-1:0] rep16(input logic [15:0] x);
    return {VEC_W/16{x}};
  endfunction

  function automatic logic [VEC_W-1:0] rndVec();
    logic [VEC_W-1:0] r;
    for (int i = 0; i < VEC_W / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; inValid = 0; sizeCode = 0; shImm = 0; srcVec = '0;
    repeat (3) @(negedge clk);
    check("R10", dstVec, '0, "reset dstVec");
    check("R10", {outValid, illegal, satAny, satFlags}, '0, "reset flags");
    rstN = 1;
    // R1: each size class decodes
    step(1, 3'b001, 3'd7, rep16(16'h1234), "R1");
    step(1, 3'b010, 3'd0, rep16(16'h8001), "R1");
    step(1, 3'b011, 3'd0, rep16(16'h00F7), "R1");
    step(1, 3'b100, 3'd0, {4{32'h0000_1234}}, "R1");
    step(1, 3'b110, 3'd3, rndVec(), "R1");
    // R2: shift extremes per size
    step(1, 3'b001, 3'd0, rep16(16'hA5C3), "R2");
    step(1, 3'b011, 3'd7, rep16(16'h00FF), "R2");
    step(1, 3'b010, 3'd0, rep16(16'hFFFF), "R2");
    step(1, 3'b111, 3'd7, {4{32'h7FFF_FFFF}}, "R2");
    step(1, 3'b100, 3'd0, {2{64'h0000_0000_8000_0000}}, "R2");
    // R3: rounding at exact half, and carry past the wide width
    step(1, 3'b001, 3'd4, {4{16'h0007, 16'h0008}}, "R3");
    step(1, 3'b100, 3'd0, {VEC_W{1'b1}}, "R3");
    step(1, 3'b010, 3'd0, {VEC_W{1'b1}}, "R3");
    step(1, 3'b001, 3'd0, {VEC_W{1'b1}}, "R3");
    // R4: saturation at the smallest shift
    step(1, 3'b001, 3'd7, rep16(16'h01FF), "R4");
    step(1, 3'b011, 3'd7, {4{32'h0001_FFFF}}, "R4");
    step(1, 3'b111, 3'd7, {2{64'h0000_0001_FFFF_FFFE}}, "R4");
    step(1, 3'b001, 3'd7, rep16(16'h01FE), "R4");
    // R6: reserved code, then R9 idle hold
    step(1, 3'b000, 3'd5, {VEC_W{1'b1}}, "R6");
    step(0, 3'b001, 3'd0, {VEC_W{1'b1}}, "R9");
    step(1, 3'b001, 3'd3, rep16(16'h0F0F), "R5");
    step(0, 3'b000, 3'd0, '0, "R9");
    step(0, 3'b100, 3'd1, rndVec(), "R9");
    // R5: random traffic over all codes, with idle gaps
    for (int i = 0; i < 600; i++) begin
      logic [2:0] sz, im;
      sz = 3'($urandom_range(0, 7));
      im = 3'($urandom_range(0, 7));
      step(($urandom_range(0, 4) != 0), sz, im,
           ($urandom_range(0, 3) == 0) ? {VEC_W{1'b1}} : rndVec(), "R5");
    end
    step(0, 3'b000, 3'd0, '0, "R9");
    step(0, 3'b000, 3'd0, '0, "R9");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule